// File: doc/BRIEF.md
# Two-Wire Presence-Detect Byte Memory Slave

This block is a two-wire serial slave that holds a 256-byte read/write memory, such as the identification data a memory module reports to its host. A faster system clock samples the bus clock and data lines. The block finds start and stop conditions and checks a 7-bit device address against a fixed prefix plus three strap pins. It then acknowledges addressed bytes, takes write transfers through a word-address pointer, and streams bytes out for as long as the master keeps acknowledging.

The data line is driven only through an active-low output enable, so the pin is open-drain. A status output reports standby. Standby is entered on a stop and left on a start. While in standby the slave ignores the bus entirely. When a read ends with a missing master acknowledge, the slave goes quiet and only a stop takes it back to standby.

Top module: `pd_eeprom_slave`

## Requirements
- R1: Out of reset, standby_o is 1 and sda_oe_n is 1, so SDA is released.
- R2: A start (SDA falling while SCL is high) drives standby_o to 0. A stop (SDA rising while SCL is high) drives standby_o to 1.
- R3: The first byte after a start is the address, sent MSB first. Bits 7..1 are compared with {4'b1010, strap_i[2:0]}, and bit 0 selects the direction (1 = read, 0 = write). On a match the slave pulls SDA low for the ninth SCL clock.
- R4: On an address mismatch there is no acknowledge, and every later byte goes unacknowledged until the next start.
- R5: In a write, the first byte after the address loads the 8-bit pointer. Each later byte is stored at the pointer. Every byte of a write is acknowledged.
- R6: In a read, the byte at the pointer is sent MSB first over eight SCL clocks and SDA is released on the ninth. If the master pulls SDA low on that ninth clock, the next byte follows.
- R7: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing until a stop. standby_o stays 0 until that stop.
- R8: The pointer advances by one after every byte written or read and wraps from 255 to 0. A read that follows a completed transfer continues from the pointer.
- R9: A repeated start, even in the middle of a byte, returns the slave to address reception. It leaves the pointer unchanged and discards the partial byte.
- R10: The slave changes its SDA drive only while SCL is low. It never drives SDA in standby. Bytes clocked in standby without a start get no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_i | input | 3 | Low three bits of the device address |
| sda_oe_n | output | 1 | Data drive enable, 0 pulls SDA low |
| standby_o | output | 1 | 1 while the slave is in standby |

## Verification
Two things share the falling SCL edge that closes a data byte: storing the byte and advancing the pointer. At byte 255 the pointer also wraps on that same edge. The bench provokes this by writing 257 bytes in one transfer from pointer 0. It judges the result by reading the whole memory back: location 0 must hold the 257th value and location 255 the 256th. A second coincidence is a repeated start arriving while a data byte is half shifted in. The bench checks that the partial byte leaves memory untouched and that the pointer still points where the word address put it.

// File: rtl/pd_pkg.sv
package pd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT_STOP
  } pd_state_e;

  typedef enum logic [1:0] {
    RK_ADDR,
    RK_WORD,
    RK_DATA
  } rx_kind_e;

endpackage

// File: rtl/pd_reset_sync.sv
module pd_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pd_bus_sync.sv
module pd_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe_q;
  logic [STAGES-1:0] sda_pipe_q;
  logic [STAGES-1:0] scl_pipe_d;
  logic [STAGES-1:0] sda_pipe_d;
  logic              scl_prev_q;
  logic              sda_prev_q;

  // Synchronizer chains, idle bus level is high
  always_comb begin
    scl_pipe_d = {scl_pipe_q[STAGES-2:0], scl_i};
    sda_pipe_d = {sda_pipe_q[STAGES-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_prev_q <= scl_pipe_q[STAGES-1];
      sda_prev_q <= sda_pipe_q[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe_q[STAGES-1];
  assign sda_s     = sda_pipe_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/pd_mem.sv
module pd_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[addr] <= wdata;
    end
  end

  assign rdata = cells[addr];

endmodule

// File: rtl/pd_ctrl.sv
module pd_ctrl
  import pd_pkg::*;
#(
  parameter int          AW         = 8,
  parameter int          DW         = 8,
  parameter int          STRAP_W    = 3,
  parameter logic [3:0]  DEV_PREFIX = 4'b1010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap,
  input  logic [DW-1:0]      rd_data,
  output logic               mem_we,
  output logic [AW-1:0]      ptr,
  output logic [DW-1:0]      wr_data,
  output logic               sda_oe_n,
  output logic               standby,
  output pd_state_e          state
);

  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] BYTE_DONE = CW'(DW);

  pd_state_e         st_q, st_d;
  rx_kind_e          kind_q, kind_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DW-1:0]     sh_q, sh_d;
  logic [AW-1:0]     ptr_q, ptr_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;
  logic              oe_n_q, oe_n_d;
  logic              sb_q, sb_d;
  logic              we_d;
  logic              addr_hit;

  assign addr_hit = (sh_q[DW-1:1] == {DEV_PREFIX, strap});

  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    ptr_d  = ptr_q;
    rw_d   = rw_q;
    mack_d = mack_q;
    oe_n_d = oe_n_q;
    sb_d   = sb_q;
    we_d   = 1'b0;

    if (stop_det) begin
      st_d   = ST_IDLE;
      sb_d   = 1'b1;
      oe_n_d = 1'b1;
      cnt_d  = '0;
    end else if (start_det) begin
      st_d   = ST_RX;
      kind_d = RK_ADDR;
      cnt_d  = '0;
      sb_d   = 1'b0;
      oe_n_d = 1'b1;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise && (cnt_q != BYTE_DONE)) begin
            sh_d  = {sh_q[DW-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && (cnt_q == BYTE_DONE)) begin
            cnt_d = '0;
            unique case (kind_q)
              RK_ADDR: begin
                if (addr_hit) begin
                  rw_d   = sh_q[0];
                  st_d   = ST_RX_ACK;
                  oe_n_d = 1'b0;
                end else begin
                  st_d = ST_IDLE;
                end
              end
              RK_WORD: begin
                ptr_d  = sh_q[AW-1:0];
                st_d   = ST_RX_ACK;
                oe_n_d = 1'b0;
              end
              default: begin
                we_d   = 1'b1;
                ptr_d  = ptr_q + 1'b1;
                st_d   = ST_RX_ACK;
                oe_n_d = 1'b0;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if ((kind_q == RK_ADDR) && rw_q) begin
              st_d   = ST_TX;
              sh_d   = rd_data;
              ptr_d  = ptr_q + 1'b1;
              oe_n_d = rd_data[DW-1];
            end else begin
              st_d   = ST_RX;
              oe_n_d = 1'b1;
              kind_d = (kind_q == RK_ADDR) ? RK_WORD : RK_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == BYTE_DONE) begin
              st_d   = ST_TX_ACK;
              cnt_d  = '0;
              oe_n_d = 1'b1;
            end else begin
              sh_d   = {sh_q[DW-2:0], 1'b0};
              oe_n_d = sh_q[DW-2];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_d   = ST_TX;
              sh_d   = rd_data;
              ptr_d  = ptr_q + 1'b1;
              oe_n_d = rd_data[DW-1];
            end else begin
              st_d   = ST_WAIT_STOP;
              oe_n_d = 1'b1;
            end
          end
        end
        default: begin
          oe_n_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= RK_ADDR;
      cnt_q  <= '0;
      sh_q   <= '0;
      ptr_q  <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      oe_n_q <= 1'b1;
      sb_q   <= 1'b1;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      ptr_q  <= ptr_d;
      rw_q   <= rw_d;
      mack_q <= mack_d;
      oe_n_q <= oe_n_d;
      sb_q   <= sb_d;
    end
  end

  assign mem_we   = we_d;
  assign ptr      = ptr_q;
  assign wr_data  = sh_q;
  assign sda_oe_n = oe_n_q;
  assign standby  = sb_q;
  assign state    = st_q;

endmodule

// File: rtl/pd_eeprom_slave.sv
module pd_eeprom_slave
  import pd_pkg::*;
#(
  parameter int         AW         = 8,
  parameter int         DW         = 8,
  parameter int         STRAP_W    = 3,
  parameter logic [3:0] DEV_PREFIX = 4'b1010,
  parameter int         SYNC_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe_n,
  output logic               standby_o
);

  logic          rst_int_n;
  logic          scl_s;
  logic          sda_s;
  logic          scl_rise;
  logic          scl_fall;
  logic          start_det;
  logic          stop_det;
  logic          mem_we;
  logic [AW-1:0] ptr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  pd_state_e     state;

  pd_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pd_bus_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  pd_ctrl #(
    .AW         (AW),
    .DW         (DW),
    .STRAP_W    (STRAP_W),
    .DEV_PREFIX (DEV_PREFIX)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .strap     (strap_i),
    .rd_data   (rd_data),
    .mem_we    (mem_we),
    .ptr       (ptr),
    .wr_data   (wr_data),
    .sda_oe_n  (sda_oe_n),
    .standby   (standby_o),
    .state     (state)
  );

  pd_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (ptr),
    .wdata (wr_data),
    .rdata (rd_data)
  );

endmodule

// File: rtl/pd_eeprom_checker.sv
module pd_eeprom_checker
  import pd_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          scl_rise,
  input logic          scl_fall,
  input logic          start_det,
  input logic          stop_det,
  input logic          sda_oe_n,
  input logic          standby_o,
  input logic          mem_we,
  input logic [AW-1:0] ptr,
  input pd_state_e     state
);

  p_stop_sets_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> standby_o);

  p_start_clears_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !standby_o);

  p_bus_events_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_det, stop_det, scl_rise, scl_fall}));

  p_nack_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_STOP) |-> sda_oe_n);

  p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (&ptr)) |=> (ptr == '0));

  p_standby_no_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    standby_o |-> sda_oe_n);

  p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe_n) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

endmodule

bind pd_eeprom_slave pd_eeprom_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .scl_s     (scl_s),
  .scl_rise  (scl_rise),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe_n  (sda_oe_n),
  .standby_o (standby_o),
  .mem_we    (mem_we),
  .ptr       (ptr),
  .state     (state)
);

// File: tb/pd_eeprom_slave_test.sv
module pd_eeprom_slave_test;

  localparam int Q = 4;

  logic       clk;
  logic       rst_n;
  logic       m_scl;
  logic       m_sda;
  logic [2:0] strap;
  logic       sda_oe_n;
  logic       standby_o;
  wire        sda_line = m_sda & sda_oe_n;

  int tests;
  int fails;
  int hi_changes;
  logic oe_prev;
  logic done;
  logic [7:0] expm [256];

  pd_eeprom_slave uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_line),
    .strap_i   (strap),
    .sda_oe_n  (sda_oe_n),
    .standby_o (standby_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // R10 monitor: drive may change only while the master holds SCL low
  always @(negedge clk) begin
    if (rst_n && (sda_oe_n !== oe_prev) && m_scl) hi_changes++;
    oe_prev = sda_oe_n;
  end

  task automatic w(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    m_scl = 1'b0; w(Q);
    m_sda = b;    w(Q);
    m_scl = 1'b1; w(2*Q);
  endtask

  task automatic bit_in(output logic b);
    m_scl = 1'b0; w(Q);
    m_sda = 1'b1; w(Q);
    m_scl = 1'b1; w(Q);
    b = sda_line; w(Q);
  endtask

  task automatic bus_start();
    m_scl = 1'b0; w(Q);
    m_sda = 1'b1; w(Q);
    m_scl = 1'b1; w(Q);
    m_sda = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    m_scl = 1'b0; w(Q);
    m_sda = 1'b0; w(Q);
    m_scl = 1'b1; w(Q);
    m_sda = 1'b1; w(2*Q);
  endtask

  // returns 1 when the slave acknowledged
  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    acked = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      bit_in(v);
      b[i] = v;
    end
    bit_out(~give_ack);
  endtask

  function automatic logic [7:0] dev(input logic [2:0] s, input logic rd);
    return {4'b1010, s, rd};
  endfunction

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic       ak;
    logic [7:0] rb;
    tests = 0; fails = 0; hi_changes = 0;
    m_scl = 1'b1; m_sda = 1'b1; strap = 3'd5; oe_prev = 1'b1;
    rst_n = 1'b0;
    w(5);
    rst_n = 1'b1;
    w(5);

    // R1 reset state
    check("R1 standby", standby_o, 1);
    check("R1 oe_n", sda_oe_n, 1);

    // R2 start/stop standby flag
    bus_start();
    check("R2 start clears standby", standby_o, 0);
    bus_stop();
    check("R2 stop sets standby", standby_o, 1);

    // R10 bytes clocked in standby without a start
    send_byte(dev(strap, 1'b0), ak);
    check("R10 no ack in standby", ak, 0);
    check("R10 still standby", standby_o, 1);

    // R3/R4 sweep all 128 write-direction addresses
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({a[6:0], 1'b0}, ak);
      check("R3 address ack", ak, (a[6:0] == {4'b1010, strap}) ? 1 : 0);
      if (a[6:0] != {4'b1010, strap}) begin
        send_byte(8'h00, ak);
        check("R4 ignored after mismatch", ak, 0);
      end
      bus_stop();
    end

    // R3 each strap value selects its own address
    for (int s = 0; s < 8; s++) begin
      strap = s[2:0];
      w(4);
      bus_start();
      send_byte(dev(s[2:0], 1'b0), ak);
      check("R3 strap match", ak, 1);
      bus_stop();
      bus_start();
      send_byte(dev(s[2:0] + 3'd1, 1'b0), ak);
      check("R3 strap mismatch", ak, 0);
      bus_stop();
    end
    strap = 3'd5;
    w(4);

    // R5/R8 write 257 bytes from pointer 0, last one wraps onto location 0
    bus_start();
    send_byte(dev(strap, 1'b0), ak);
    check("R5 address ack", ak, 1);
    send_byte(8'h00, ak);
    check("R5 word address ack", ak, 1);
    for (int k = 0; k < 257; k++) begin
      logic [7:0] v;
      v = 8'((k * 29 + 7) & 255);
      expm[k & 255] = v;
      send_byte(v, ak);
      check("R5 data ack", ak, 1);
    end
    bus_stop();

    // R9/R6/R8 random read over the wrap: word FE, repeated start, read 3
    bus_start();
    send_byte(dev(strap, 1'b0), ak);
    send_byte(8'hFE, ak);
    bus_start();
    send_byte(dev(strap, 1'b1), ak);
    check("R9 read address ack after repeated start", ak, 1);
    recv_byte(rb, 1'b1);
    check("R9 data at word address", rb, expm[8'hFE]);
    recv_byte(rb, 1'b1);
    check("R6 next byte after master ack", rb, expm[8'hFF]);
    recv_byte(rb, 1'b0);
    check("R8 read wraps to 0", rb, expm[8'h00]);

    // R7 after the missing ack the slave stays released until a stop
    for (int i = 0; i < 9; i++) begin
      logic v;
      bit_in(v);
      check("R7 released after nack", v, 1);
    end
    check("R7 standby held low until stop", standby_o, 0);
    bus_stop();
    check("R7 stop ends transfer", standby_o, 1);

    // R8/R6 current-address read continues at 01 and sweeps all 256
    bus_start();
    send_byte(dev(strap, 1'b1), ak);
    check("R6 read address ack", ak, 1);
    for (int i = 0; i < 256; i++) begin
      recv_byte(rb, (i != 255));
      check("R8 sequential read", rb, expm[(1 + i) & 255]);
    end
    bus_stop();

    // R9 repeated start inside a data byte: nothing stored, pointer kept
    bus_start();
    send_byte(dev(strap, 1'b0), ak);
    send_byte(8'h80, ak);
    check("R9 word address ack", ak, 1);
    bit_out(1'b0);
    bit_out(1'b1);
    bit_out(1'b0);
    bus_start();
    send_byte(dev(strap, 1'b1), ak);
    check("R9 address ack after mid-byte restart", ak, 1);
    recv_byte(rb, 1'b1);
    check("R9 pointer kept, memory untouched", rb, expm[8'h80]);
    recv_byte(rb, 1'b0);
    check("R9 following byte", rb, expm[8'h81]);
    bus_stop();

    check("R10 drive changed while SCL high", hi_changes, 0);
    check("R10 idle released", sda_oe_n, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule